// File: doc/BRIEF.md
# Escalating Watchdog Timer Bank

A bank of countdown watchdog timers behind a 64-bit register interface. Each timer counts down from a programmed length. Software keeps it alive by writing a keep-alive value to that timer's own poke register. If software stops doing so, the timer expires repeatedly and each expiry escalates one step. The first step flags a pending interrupt for the main core. The second step raises an interrupt for a management processor. The third step asserts a system reset request.

All timers count on one shared prescaler tick that fires once every `PRESC` clock cycles. Each timer holds a 24-bit live count whose low 8 bits are zero after every load, so one length unit equals 256 ticks. Pending bits and enable bits sit in shared registers with one bit per timer. The pending register is cleared by writing 1 to a bit. The enable bits are set and cleared through two separate registers, and only the bits written as 1 change. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational on `addr`.

Top module: `esc_wdog`

## Requirements
- R1: After reset, every control word, the pending register and the enable register read 0, and `core_irq`, `mgmt_irq` and `rst_req` are low.
- R2: The control word of timer i sits at byte address 8*i. It holds the mode in bits [1:0], the management interrupt enable in bit 2, the 16-bit length in bits [19:4] and the read-only 24-bit live count in bits [43:20]. All other bits read 0.
- R3: A control write that changes the mode from 0 to a non-zero value loads the count with length*256 (length in count bits [23:8], zeros below) and restarts escalation from the first stage. A control write from one non-zero mode to another leaves the count running.
- R4: While its mode is non-zero, a timer decrements once per prescaler tick (every `PRESC` cycles). The first expiry comes length*256 ticks after a load. It sets the timer's bit in the pending register. `core_irq` is high when any timer has both its pending bit and its enable bit set.
- R5: In modes 2 and 3, the second expiry drives `mgmt_irq` high only if bit 2 of that timer's control word is 1. `mgmt_irq` then stays high until a valid poke or a write of mode 0.
- R6: In mode 3, the third expiry asserts `rst_req`. It stays high until the block is reset, whatever pokes follow.
- R7: Writing the enable-set register (0x218) sets the enable bits written as 1. Writing the enable-clear register (0x210) clears the enable bits written as 1. Bits written as 0 keep their value. Both addresses read back the enable bits (bit i for timer i).
- R8: The pending register (0x200) clears only the bits written as 1. An expiry that lands in the same cycle as a clear wins.
- R9: Writing exactly 1 to timer i's poke register (0x10000 + 8*i) reloads the count to length*256, returns escalation to the first stage and drops that timer's management interrupt.
- R10: A poke write with any value other than 1 is ignored, and the expiry schedule is unchanged.
- R11: Mode 1 sets the pending bit on every expiry and never raises `mgmt_irq` or `rst_req`.
- R12: Mode 2 raises `mgmt_irq` on the second expiry (when enabled) and never asserts `rst_req`.
- R13: In mode 0 the count is frozen and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the access at `addr` |
| addr | input | 17 | Byte address, 8-byte aligned |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| core_irq | output | 1 | Main-core interrupt: any pending and enabled timer |
| mgmt_irq | output | 1 | Management processor interrupt, OR over timers |
| rst_req | output | 1 | Sticky reset request, OR over timers |

## Verification
On every cycle, the assertions check four things:
- New pending bits, a rising management interrupt and a rising reset request appear only right after a prescaler tick.
- Pending bits drop only after a write to the pending register.
- The management interrupt falls only after a write.
- The reset request never drops once it is set.

The bench scenarios cover the rest:
- the length*256-tick expiry spacing, checked to within one tick;
- the stage order under each mode;
- a poke placed before the second and before the third stage, which holds back escalation;
- an invalid poke value, which is ignored;
- the mask behaviour of the set, clear and write-1-to-clear registers.

// File: rtl/esc_wdog.sv
module esc_wdog #(
  parameter int NUM_TMR = 64,
  parameter int PRESC   = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [16:0] addr,
  input  logic [63:0] wdata,
  output logic [63:0] rdata,
  output logic        core_irq,
  output logic        mgmt_irq,
  output logic        rst_req
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [16:0] A_PEND = 17'h00200;
  localparam logic [16:0] A_ECLR = 17'h00210;
  localparam logic [16:0] A_ESET = 17'h00218;
  localparam logic [16:0] A_POKE = 17'h10000;

  logic [PW-1:0]      pre_q;
  logic               tick;
  logic [NUM_TMR-1:0] pend_q, ena_q, pend_set, pend_clr, ena_set, ena_clr;
  logic [NUM_TMR-1:0] mg_vec, rs_vec;
  logic [63:0]        word [NUM_TMR];
  logic               unused_bits;

  assign unused_bits = ^{wdata[63:20], wdata[3]};

  assign tick = (pre_q == PW'(PRESC - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [1:0]  mode_q, stage_q, mode_n;
    logic        men_q, mg_q, rs_q;
    logic [15:0] len_q;
    logic [23:0] cnt_q;
    logic        ctl_hit, poke, start, expire;

    assign ctl_hit = wr_en && (addr == 17'(8 * i));
    assign poke    = wr_en && (addr == A_POKE + 17'(8 * i)) && (wdata == 64'd1);
    assign mode_n  = wdata[1:0];
    assign start   = ctl_hit && (mode_q == 2'd0) && (mode_n != 2'd0);
    assign expire  = tick && (mode_q != 2'd0) && (cnt_q <= 24'd1);

    assign pend_set[i] = expire && (stage_q == 2'd0 || mode_q == 2'd1);
    assign mg_vec[i]   = mg_q;
    assign rs_vec[i]   = rs_q;
    assign word[i]     = {20'h0, cnt_q, len_q, 1'b0, men_q, mode_q};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q  <= 2'd0;
        men_q   <= 1'b0;
        len_q   <= '0;
        cnt_q   <= '0;
        stage_q <= 2'd0;
        mg_q    <= 1'b0;
        rs_q    <= 1'b0;
      end else begin
        if (ctl_hit) begin
          mode_q <= mode_n;
          men_q  <= wdata[2];
          len_q  <= wdata[19:4];
        end
        if (start) begin
          cnt_q   <= {wdata[19:4], 8'h00};
          stage_q <= 2'd0;
        end else if (poke) begin
          cnt_q   <= {len_q, 8'h00};
          stage_q <= 2'd0;
        end else if (expire) begin
          cnt_q <= {len_q, 8'h00};
          case (stage_q)
            2'd0:    stage_q <= 2'd1;
            2'd1:    stage_q <= (mode_q >= 2'd2) ? 2'd2 : 2'd1;
            2'd2:    stage_q <= (mode_q == 2'd3) ? 2'd3 : 2'd2;
            default: stage_q <= 2'd3;
          endcase
        end else if (tick && mode_q != 2'd0) begin
          cnt_q <= cnt_q - 24'd1;
        end
        if (poke || (ctl_hit && mode_n == 2'd0))
          mg_q <= 1'b0;
        else if (expire && stage_q == 2'd1 && mode_q >= 2'd2 && men_q)
          mg_q <= 1'b1;
        if (expire && stage_q == 2'd2 && mode_q == 2'd3)
          rs_q <= 1'b1;
      end
    end
  end

  assign pend_clr = (wr_en && addr == A_PEND) ? wdata[NUM_TMR-1:0] : '0;
  assign ena_set  = (wr_en && addr == A_ESET) ? wdata[NUM_TMR-1:0] : '0;
  assign ena_clr  = (wr_en && addr == A_ECLR) ? wdata[NUM_TMR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      ena_q  <= (ena_q | ena_set) & ~ena_clr;
    end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TMR; i++)
      if (addr == 17'(8 * i)) rdata = word[i];
    if (addr == A_PEND) rdata = 64'(pend_q);
    if (addr == A_ECLR || addr == A_ESET) rdata = 64'(ena_q);
  end

  assign core_irq = |(pend_q & ena_q);
  assign mgmt_irq = |mg_vec;
  assign rst_req  = |rs_vec;
endmodule

module esc_wdog_chk #(
  parameter int NUM_TMR = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [16:0]        addr,
  input logic [NUM_TMR-1:0] pend,
  input logic               tick,
  input logic               mgmt_irq,
  input logic               rst_req
);
  a_r4_pend_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend))) |-> $past(tick));

  a_r5_mgmt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgmt_irq) |-> $past(tick));

  a_r6_rst_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(tick));

  a_r6_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  a_r8_pend_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> $past(wr_en && addr == 17'h00200));

  a_r9_mgmt_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mgmt_irq) |-> $past(wr_en));
endmodule

bind esc_wdog esc_wdog_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .pend(pend_q), .tick(tick), .mgmt_irq(mgmt_irq), .rst_req(rst_req)
);

// File: tb/esc_wdog_bench.sv
module esc_wdog_bench;
  localparam int NT = 4;
  localparam int PS = 2;
  localparam logic [16:0] A_PEND = 17'h00200;
  localparam logic [16:0] A_ECLR = 17'h00210;
  localparam logic [16:0] A_ESET = 17'h00218;
  localparam logic [16:0] A_POKE = 17'h10000;

  localparam logic [144:0] VEC [6] = '{
    {A_ESET, 64'h5, 64'h5},
    {A_ESET, 64'h2, 64'h7},
    {A_ECLR, 64'h4, 64'h3},
    {A_ECLR, 64'h0, 64'h3},
    {A_ESET, 64'h8, 64'hB},
    {A_ECLR, 64'h9, 64'h2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        core_irq, mgmt_irq, rst_req;
  int          n_chk = 0;
  int          n_bad = 0;

  esc_wdog #(.NUM_TMR(NT), .PRESC(PS)) u_esc_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_irq(core_irq), .mgmt_irq(mgmt_irq), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] cw(input logic [1:0] m, input logic me, input logic [15:0] l);
    return {44'h0, l, 1'b0, me, m};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    do_reset();
    // R1 reset state
    check("R1 core_irq", 64'(core_irq), 64'd0);
    check("R1 mgmt_irq", 64'(mgmt_irq), 64'd0);
    check("R1 rst_req", 64'(rst_req), 64'd0);
    rd(A_PEND, d); check("R1 pending", d, 64'd0);
    rd(A_ESET, d); check("R1 enable", d, 64'd0);
    rd(17'h0, d);  check("R1 ctrl0", d, 64'd0);

    // R7 enable set/clear vector table
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][144:128], VEC[k][127:64]);
      rd(A_ESET, d); check("R7 enable via set addr", d, VEC[k][63:0]);
      rd(A_ECLR, d); check("R7 enable via clr addr", d, VEC[k][63:0]);
    end

    // R2/R3 control layout, load on start, no reload on nonzero->nonzero
    do_reset();
    wr(17'h18, cw(2'd3, 1'b1, 16'h00A5));
    rd(17'h18, d);
    check("R2 mode/men/len", {d[63:44], 24'h0, d[19:0]}, cw(2'd3, 1'b1, 16'h00A5));
    check("R3 count loaded", 64'(d[43:20] >= 24'hA4FD && d[43:20] <= 24'hA500), 64'd1);
    wr(17'h18, cw(2'd0, 1'b1, 16'h00A5));
    rd(17'h18, d);
    waitc(40);
    rd(17'h18, d2);
    check("R13 count frozen in mode 0", 64'(d2[43:20]), 64'(d[43:20]));
    wr(17'h18, cw(2'd1, 1'b0, 16'h0033));
    rd(17'h18, d);
    check("R3 restart loads new length", 64'(d[43:20] >= 24'h32FD && d[43:20] <= 24'h3300), 64'd1);
    wr(17'h18, cw(2'd3, 1'b0, 16'h0077));
    rd(17'h18, d);
    check("R3 running edit keeps count", 64'(d[43:20] <= 24'h3300 && d[43:20] >= 24'h32F0), 64'd1);
    check("R2 length updated", 64'(d[19:4]), 64'h77);

    // R4 R5 R6 full escalation, timer 0
    do_reset();
    wr(A_ESET, 64'h1);
    wr(17'h0, cw(2'd3, 1'b1, 16'h1));
    waitc(509); check("R4 no expiry before 256 ticks", 64'(core_irq), 64'd0);
    waitc(5);   check("R4 first expiry raises core_irq", 64'(core_irq), 64'd1);
    check("R4 mgmt still low", 64'(mgmt_irq), 64'd0);
    waitc(507); check("R5 mgmt low before second", 64'(mgmt_irq), 64'd0);
    waitc(5);   check("R5 second expiry raises mgmt", 64'(mgmt_irq), 64'd1);
    waitc(507); check("R6 rst low before third", 64'(rst_req), 64'd0);
    waitc(5);   check("R6 third expiry asserts rst", 64'(rst_req), 64'd1);
    // R8 pending clear mask
    wr(A_PEND, 64'h0);
    rd(A_PEND, d); check("R8 write 0 keeps pending", d, 64'h1);
    wr(A_PEND, 64'h1);
    rd(A_PEND, d); check("R8 write 1 clears pending", d, 64'h0);
    check("R8 core_irq drops", 64'(core_irq), 64'd0);
    wr(A_POKE, 64'h1);
    waitc(2); check("R6 rst sticky after poke", 64'(rst_req), 64'd1);

    // R9 poke holds back escalation, timer 1
    do_reset();
    wr(A_ESET, 64'h2);
    wr(17'h8, cw(2'd3, 1'b1, 16'h1));
    waitc(514); check("R4 timer1 pending", 64'(core_irq), 64'd1);
    wr(A_POKE + 17'h8, 64'h1);
    waitc(600); check("R9 poke blocks second stage", 64'(mgmt_irq), 64'd0);
    waitc(426); check("R9 second stage after poke", 64'(mgmt_irq), 64'd1);
    wr(A_POKE + 17'h8, 64'h1);
    waitc(1); check("R9 poke drops mgmt", 64'(mgmt_irq), 64'd0);
    waitc(700); check("R9 poke blocks reset", 64'(rst_req), 64'd0);

    // R10 R11 mode 1 and ignored poke, timer 2
    do_reset();
    wr(A_ESET, 64'h4);
    wr(17'h10, cw(2'd1, 1'b1, 16'h1));
    waitc(300);
    wr(A_POKE + 17'h10, 64'h2);
    waitc(208); check("R10 no early expiry", 64'(core_irq), 64'd0);
    waitc(5);   check("R10 bad poke ignored, expiry on time", 64'(core_irq), 64'd1);
    wr(A_PEND, 64'h4);
    check("R11 pending cleared", 64'(core_irq), 64'd0);
    waitc(511); check("R11 repeated pending", 64'(core_irq), 64'd1);
    check("R11 no mgmt", 64'(mgmt_irq), 64'd0);
    waitc(600); check("R11 no reset", 64'(rst_req), 64'd0);

    // R12 mode 2, timer 3
    do_reset();
    wr(17'h18, cw(2'd2, 1'b1, 16'h1));
    waitc(1026); check("R12 mgmt in mode 2", 64'(mgmt_irq), 64'd1);
    waitc(700);  check("R12 no reset in mode 2", 64'(rst_req), 64'd0);

    // R5 mgmt disabled, timer 1
    do_reset();
    wr(17'h8, cw(2'd3, 1'b0, 16'h1));
    waitc(1300); check("R5 mgmt stays low when disabled", 64'(mgmt_irq), 64'd0);
    waitc(238);  check("R6 reset still asserted", 64'(rst_req), 64'd1);

    // R13 stop
    do_reset();
    wr(A_ESET, 64'h1);
    wr(17'h0, cw(2'd1, 1'b0, 16'h1));
    waitc(300);
    wr(17'h0, cw(2'd0, 1'b0, 16'h1));
    waitc(600); check("R13 no expiry in mode 0", 64'(core_irq), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule